// File: doc/BRIEF.md
# Search-Result Read Address and Burst Sequencer

This block sits behind the command decoder of a content-addressable search device. When a read command arrives, it takes the 72-bit bus word and works out which storage target to read: the data array, the mask array, an external SRAM or the device register space. It also works out which address to read. It then drives a read strobe with an array select and an address into that target, one access per clock cycle, and pulses a completion flag when the command is finished.

A single read takes its address from the bus word in one of two ways. In direct mode the address is the low sixteen bits of the word. In indirect mode the address comes from one of eight stored search-result registers, and the two low address bits from the bus are merged into it with a bitwise OR. This lets software pick a neighbouring entry of a search hit.

A burst read takes its start address and length from a burst-setup input. It walks consecutive addresses with one strobe per cycle. Bursts are allowed only on the two internal arrays. A burst aimed at the SRAM or the register space is refused with an error flag. The block accepts a new command only while it is idle, and it shows its state on a busy output.

Top module: `srch_read_seq`

## Requirements
- R1: A single read (`cmdBurst`=0) accepted at a rising edge gives exactly one cycle with `rdStrobe`=1 in the next cycle. In that cycle `rdSel` equals bus bits 20:19, where 00 is the data array, 01 the mask array, 10 the external SRAM and 11 the register space. In direct mode (bus bit 29 = 0), `rdAddr` equals bus bits 15:0. `done` is high in the cycle after the strobe. A single read is allowed on all four targets.
- R2: In indirect mode (bus bit 29 = 1), bus bits 28:26 select search-result register k. Register k is `resultRegs[16k+15:16k]`. The read address is {reg[15:2], reg[1] OR bus[1], reg[0] OR bus[0]}.
- R3: A burst (`cmdBurst`=1) to target 00 or 01 with length N > 0 gives N consecutive strobe cycles, starting in the cycle after acceptance. The addresses are `burstStart`, `burstStart`+1, and so on, wrapping modulo 2^16. `done` is high in the cycle after the last strobe.
- R4: A burst with length 0 gives no strobe, and `done` is high in the cycle after acceptance.
- R5: A burst to target 10 or 11 gives no strobe. `errFlag` and `done` are both high in the cycle after acceptance.
- R6: Bus bits 71:30, 25:21 and 18:16 have no effect on any output.
- R7: `busy` is high from the cycle after acceptance up to and including the `done` cycle. A `cmdValid` that arrives while `busy` is high is ignored, and `rdSel` holds steady while busy.
- R8: `done` lasts exactly one cycle. `errFlag` is high only together with `done` and never together with `rdStrobe`.
- R9: While reset is held and after it is released, `rdStrobe`, `done`, `busy` and `errFlag` are low.
- R10: A burst takes its address only from `burstStart`. Bus bit 29 and bus bits 15:0 have no effect on a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A read command is present this cycle |
| cmdBurst | input | 1 | 0 = single read, 1 = burst read |
| busWord | input | 72 | Bus word that carries the addressing fields |
| burstStart | input | 16 | Start address for a burst |
| burstLen | input | 8 | Number of accesses in a burst |
| resultRegs | input | 128 | Eight 16-bit search-result registers, packed |
| rdSel | output | 2 | Target select for the current access |
| rdAddr | output | 16 | Read address |
| rdStrobe | output | 1 | One access this cycle |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A command is in progress |
| errFlag | output | 1 | Refused burst, shown together with done |

## Verification
Single reads are tried on all four targets with direct addresses. The reserved bus fields are filled first with zeros and then with random ones, which separates true field decoding from accidental use of reserved bits. Indirect reads combine register values and bus low bits so that each OR term is exercised in both directions, across several register indices. Bursts are tried with lengths 0, 1 and several beats, including a start near the top of the address space so that the wrap shows. A junk direct address and bit 29 are set on a burst, and refused bursts go to both the SRAM and the register space. Extra commands held on `cmdValid` while the block is busy must produce no extra strobes or completions.

// File: rtl/srs_pkg.sv
package srs_pkg;

  // Field positions inside the bus word; neighbours decode these fixed places.
  localparam int POS_INDIRECT = 29;
  localparam int POS_RIDX_LO  = 26;
  localparam int RIDX_W       = 3;
  localparam int POS_TGT_LO   = 19;
  localparam int TGT_W        = 2;

  typedef enum logic [1:0] {
    TGT_DATA = 2'b00,
    TGT_MASK = 2'b01,
    TGT_SRAM = 2'b10,
    TGT_REGS = 2'b11
  } target_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_ACCESS = 2'b01,
    ST_FINISH = 2'b10
  } seqState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // capture target, address and beat count
    logic burst;  // load comes from the burst-setup inputs
    logic step;   // advance to the next beat
  } dpStrobe_t;

endpackage

// File: rtl/srs_dpath.sv
module srs_dpath
  import srs_pkg::*;
#(
  parameter int BUS_W   = 72,
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 8,
  parameter int NUM_RES = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strb,
  input  logic [BUS_W-1:0]          busWord,
  input  logic [ADDR_W-1:0]         burstStart,
  input  logic [LEN_W-1:0]          burstLen,
  input  logic [NUM_RES*ADDR_W-1:0] resultRegs,
  output logic [TGT_W-1:0]          rdSel,
  output logic [ADDR_W-1:0]         rdAddr,
  output logic                      lastBeat
);

  localparam int RES_TOP = POS_INDIRECT + 1;

  logic [ADDR_W-1:0] resArr [NUM_RES];
  logic [RIDX_W-1:0] resIdx;
  logic [ADDR_W-1:0] chosenRes;
  logic [ADDR_W-1:0] indirectAddr;
  logic [ADDR_W-1:0] singleAddr;
  logic [ADDR_W-1:0] addrReg;
  logic [LEN_W-1:0]  cntReg;
  logic [TGT_W-1:0]  selReg;
  logic              unusedBits;

  // Unpack the register file.
  for (genvar k = 0; k < NUM_RES; k++) begin : g_unpack
    assign resArr[k] = resultRegs[k*ADDR_W +: ADDR_W];
  end

  assign resIdx = busWord[POS_RIDX_LO +: RIDX_W];

  always_comb begin
    chosenRes = '0;
    if (int'(resIdx) < NUM_RES) chosenRes = resArr[resIdx];
  end

  // The two low bits from the bus are ORed into the stored address.
  assign indirectAddr = {chosenRes[ADDR_W-1:2], chosenRes[1:0] | busWord[1:0]};
  assign singleAddr   = busWord[POS_INDIRECT] ? indirectAddr : busWord[ADDR_W-1:0];

  assign unusedBits = ^{busWord[BUS_W-1:RES_TOP], busWord[POS_RIDX_LO-1:POS_TGT_LO+TGT_W],
                        busWord[POS_TGT_LO-1:ADDR_W]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      cntReg  <= '0;
      selReg  <= '0;
    end else if (strb.load) begin
      selReg  <= busWord[POS_TGT_LO +: TGT_W];
      addrReg <= strb.burst ? burstStart : singleAddr;
      cntReg  <= strb.burst ? burstLen : LEN_W'(1);
    end else if (strb.step) begin
      addrReg <= addrReg + 1'b1;
      cntReg  <= cntReg - 1'b1;
    end
  end

  assign rdSel    = selReg;
  assign rdAddr   = addrReg;
  assign lastBeat = (cntReg == LEN_W'(1));

  // R3: each step moves the address forward by one.
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.step) && !$past(strb.load) |-> rdAddr == $past(rdAddr) + 1'b1);

endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdBurst,
  input  logic [TGT_W-1:0] target,
  input  logic [LEN_W-1:0] burstLen,
  input  logic             lastBeat,
  output dpStrobe_t        strb,
  output logic             rdStrobe,
  output logic             done,
  output logic             busy,
  output logic             errFlag
);

  seqState_e state, stateNext;
  logic      errReg, errNext;
  logic      accept;
  logic      burstOk;
  logic      emptyBurst;

  assign accept     = cmdValid && (state == ST_IDLE);
  assign burstOk    = (target == TGT_DATA) || (target == TGT_MASK);
  assign emptyBurst = (burstLen == '0);

  always_comb begin
    stateNext  = state;
    errNext    = errReg;
    strb       = '0;
    unique case (state)
      ST_IDLE: begin
        errNext = 1'b0;
        if (accept) begin
          if (!cmdBurst) begin
            strb.load = 1'b1;
            stateNext = ST_ACCESS;
          end else if (!burstOk) begin
            errNext   = 1'b1;
            stateNext = ST_FINISH;
          end else if (emptyBurst) begin
            stateNext = ST_FINISH;
          end else begin
            strb.load  = 1'b1;
            strb.burst = 1'b1;
            stateNext  = ST_ACCESS;
          end
        end
      end
      ST_ACCESS: begin
        if (lastBeat) stateNext = ST_FINISH;
        else          strb.step = 1'b1;
      end
      ST_FINISH: begin
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      errReg <= 1'b0;
    end else begin
      state  <= stateNext;
      errReg <= errNext;
    end
  end

  assign rdStrobe = (state == ST_ACCESS);
  assign done     = (state == ST_FINISH);
  assign busy     = (state != ST_IDLE);
  assign errFlag  = errReg && done;

  // R8: completion lasts one cycle.
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: error only alongside completion, never with an access.
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> done && !rdStrobe);

  // R1: single read strobes once, then completes.
  a_r1_single_shape: assert property (@(posedge clk) disable iff (!rstN)
    accept && !cmdBurst |=> rdStrobe ##1 (done && !rdStrobe));

  // R4: empty burst completes with no access.
  a_r4_empty_burst: assert property (@(posedge clk) disable iff (!rstN)
    accept && cmdBurst && emptyBurst |=> done && !rdStrobe);

  // R5: refused burst flags an error on the next cycle.
  a_r5_refused_burst: assert property (@(posedge clk) disable iff (!rstN)
    accept && cmdBurst && !burstOk |=> errFlag && !rdStrobe);

endmodule

// File: rtl/srch_read_seq.sv
module srch_read_seq
  import srs_pkg::*;
#(
  parameter int BUS_W   = 72,
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 8,
  parameter int NUM_RES = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cmdValid,
  input  logic                      cmdBurst,
  input  logic [BUS_W-1:0]          busWord,
  input  logic [ADDR_W-1:0]         burstStart,
  input  logic [LEN_W-1:0]          burstLen,
  input  logic [NUM_RES*ADDR_W-1:0] resultRegs,
  output logic [1:0]                rdSel,
  output logic [ADDR_W-1:0]         rdAddr,
  output logic                      rdStrobe,
  output logic                      done,
  output logic                      busy,
  output logic                      errFlag
);

  dpStrobe_t strb;
  logic      lastBeat;

  srs_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdBurst (cmdBurst),
    .target   (busWord[POS_TGT_LO +: TGT_W]),
    .burstLen (burstLen),
    .lastBeat (lastBeat),
    .strb     (strb),
    .rdStrobe (rdStrobe),
    .done     (done),
    .busy     (busy),
    .errFlag  (errFlag)
  );

  srs_dpath #(
    .BUS_W   (BUS_W),
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .NUM_RES (NUM_RES)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWord    (busWord),
    .burstStart (burstStart),
    .burstLen   (burstLen),
    .resultRegs (resultRegs),
    .rdSel      (rdSel),
    .rdAddr     (rdAddr),
    .lastBeat   (lastBeat)
  );

  // R7: the target stays put while a command runs.
  a_r7_sel_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(rdSel));

  // R7: accesses only while busy.
  a_r7_strobe_busy: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |-> busy);

endmodule

// File: tb/sim_srch_read_seq.sv
`timescale 1ns/1ps
module sim_srch_read_seq;

  typedef struct {
    bit          isDone;
    bit          err;
    logic [1:0]  sel;
    logic [15:0] addr;
    string       req;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdValid = 1'b0;
  logic         cmdBurst = 1'b0;
  logic [71:0]  busWord = '0;
  logic [15:0]  burstStart = '0;
  logic [7:0]   burstLen = '0;
  logic [127:0] resultRegs = '0;
  logic [1:0]   rdSel;
  logic [15:0]  rdAddr;
  logic         rdStrobe, done, busy, errFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  srch_read_seq u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdBurst(cmdBurst),
    .busWord(busWord), .burstStart(burstStart), .burstLen(burstLen),
    .resultRegs(resultRegs), .rdSel(rdSel), .rdAddr(rdAddr),
    .rdStrobe(rdStrobe), .done(done), .busy(busy), .errFlag(errFlag)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [71:0] mkWord(input bit ind, input int ridx, input logic [1:0] tgt,
                                         input logic [15:0] addr, input bit junk);
    logic [71:0] w;
    w = junk ? {$urandom, $urandom, $urandom} : '0;
    w[29]    = ind;
    w[28:26] = ridx[2:0];
    w[20:19] = tgt;
    w[15:0]  = addr;
    return w;
  endfunction

  function automatic logic [15:0] resVal(input int k);
    return resultRegs[k*16 +: 16];
  endfunction

  // Driver: builds expectations from the requirements, then drives the command.
  task automatic issue(input bit burst, input logic [71:0] w, input bit pokeBusy, input string req);
    expItem_t it;
    logic [1:0]  tgt;
    logic [15:0] a, r;
    tgt = w[20:19];
    if (!burst) begin
      if (w[29]) begin
        r = resVal(int'(w[28:26]));
        a = {r[15:2], r[1:0] | w[1:0]};
      end else begin
        a = w[15:0];
      end
      it = '{1'b0, 1'b0, tgt, a, req};
      expQ.push_back(it);
      it = '{1'b1, 1'b0, 2'b00, 16'h0, req};
      expQ.push_back(it);
    end else if (tgt[1]) begin
      it = '{1'b1, 1'b1, 2'b00, 16'h0, req};
      expQ.push_back(it);
    end else begin
      for (int i = 0; i < int'(burstLen); i++) begin
        it = '{1'b0, 1'b0, tgt, burstStart + 16'(i), req};
        expQ.push_back(it);
      end
      it = '{1'b1, 1'b0, 2'b00, 16'h0, req};
      expQ.push_back(it);
    end
    while (busy) @(negedge clk);
    cmdValid = 1'b1;
    cmdBurst = burst;
    busWord  = w;
    @(posedge clk);
    @(negedge clk);
    check("R7", "busy after accept", 32'(busy), 32'd1);
    if (pokeBusy) begin
      // R7: a second command while busy must leave no trace.
      cmdBurst = 1'b0;
      busWord  = mkWord(1'b0, 0, 2'b01, 16'hDEAD, 1'b1);
      @(posedge clk);
      @(negedge clk);
    end
    cmdValid = 1'b0;
    busWord  = {$urandom, $urandom, $urandom};
  endtask

  // Monitor: pops one expectation per strobe or completion.
  always @(negedge clk) begin
    if (rstN && !finished && (rdStrobe || done)) begin
      if (expQ.size() == 0) begin
        check("R7", "unexpected output event", {30'd0, rdStrobe, done}, 32'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (e.isDone) begin
          check(e.req, "done", 32'(done), 32'd1);
          check(e.req, "strobe with done", 32'(rdStrobe), 32'd0);
          check(e.req, "errFlag", 32'(errFlag), 32'(e.err));
        end else begin
          check(e.req, "strobe", 32'(rdStrobe), 32'd1);
          check(e.req, "rdSel", 32'(rdSel), 32'(e.sel));
          check(e.req, "rdAddr", 32'(rdAddr), 32'(e.addr));
          check("R8", "errFlag with strobe", 32'(errFlag), 32'd0);
        end
      end
    end
  end

  task automatic finish();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish();
  end

  initial begin
    // Search-result registers k = 0..7.
    resultRegs[0*16 +: 16] = 16'h1000;
    resultRegs[3*16 +: 16] = 16'hABC2;
    resultRegs[5*16 +: 16] = 16'h7FF1;
    resultRegs[7*16 +: 16] = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R9: quiet during reset.
    check("R9", "reset outputs", {28'd0, rdStrobe, done, busy, errFlag}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", "after reset outputs", {28'd0, rdStrobe, done, busy, errFlag}, 32'd0);

    // R1: direct single reads on every target.
    issue(1'b0, mkWord(1'b0, 0, 2'b00, 16'h1234, 1'b0), 1'b0, "R1");
    issue(1'b0, mkWord(1'b0, 0, 2'b10, 16'h00FF, 1'b0), 1'b0, "R1");
    issue(1'b0, mkWord(1'b0, 0, 2'b11, 16'h0042, 1'b0), 1'b0, "R1");
    // R6: reserved fields filled with random bits.
    issue(1'b0, mkWord(1'b0, 6, 2'b01, 16'hC0DE, 1'b1), 1'b0, "R6");
    issue(1'b0, mkWord(1'b0, 2, 2'b00, 16'h0003, 1'b1), 1'b0, "R6");

    // R2: indirect reads, OR of low bits both ways.
    issue(1'b0, mkWord(1'b1, 3, 2'b00, 16'h0001, 1'b0), 1'b0, "R2");
    issue(1'b0, mkWord(1'b1, 5, 2'b01, 16'h5552, 1'b1), 1'b0, "R2");
    issue(1'b0, mkWord(1'b1, 0, 2'b10, 16'h0000, 1'b0), 1'b0, "R2");
    issue(1'b0, mkWord(1'b1, 7, 2'b11, 16'h0000, 1'b1), 1'b0, "R2");

    // R3: bursts on data and mask, with wrap.
    burstStart = 16'h1230; burstLen = 8'd4;
    issue(1'b1, mkWord(1'b0, 0, 2'b00, 16'h9999, 1'b0), 1'b0, "R3");
    burstStart = 16'hFFFE; burstLen = 8'd3;
    issue(1'b1, mkWord(1'b0, 0, 2'b01, 16'h0000, 1'b1), 1'b0, "R3");
    burstStart = 16'h0500; burstLen = 8'd1;
    issue(1'b1, mkWord(1'b0, 0, 2'b00, 16'h0000, 1'b0), 1'b0, "R3");
    // R10: indirect bit and bus address are not used by a burst.
    burstStart = 16'h2000; burstLen = 8'd5;
    issue(1'b1, mkWord(1'b1, 3, 2'b01, 16'hBEEF, 1'b1), 1'b0, "R10");

    // R4: empty burst.
    burstLen = 8'd0;
    issue(1'b1, mkWord(1'b0, 0, 2'b00, 16'h0000, 1'b0), 1'b0, "R4");

    // R5: refused bursts to SRAM and register space.
    burstLen = 8'd6;
    issue(1'b1, mkWord(1'b0, 0, 2'b10, 16'h0010, 1'b0), 1'b0, "R5");
    issue(1'b1, mkWord(1'b0, 0, 2'b11, 16'h0010, 1'b1), 1'b0, "R5");

    // R7: commands offered while busy are ignored.
    issue(1'b0, mkWord(1'b0, 0, 2'b00, 16'h4444, 1'b0), 1'b1, "R7");
    burstStart = 16'h0100; burstLen = 8'd3;
    issue(1'b1, mkWord(1'b0, 0, 2'b00, 16'h0000, 1'b0), 1'b1, "R7");
    burstLen = 8'd0;
    issue(1'b1, mkWord(1'b0, 0, 2'b01, 16'h0000, 1'b0), 1'b1, "R7");
    burstLen = 8'd2;
    issue(1'b1, mkWord(1'b0, 0, 2'b10, 16'h0000, 1'b0), 1'b1, "R5");

    for (int i = 0; i < 20 && expQ.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R8", "expectations left", 32'(expQ.size()), 32'd0);
    check("R7", "idle at end", 32'(busy), 32'd0);
    finish();
  end

endmodule